// File: doc/BRIEF.md
# Word-Clock Sample Rate Classifier

This block classifies the sample rate of an incoming audio stream from its word clock alone. A free-running crystal reference clock drives the logic. The word clock is asynchronous to it. A counter in the reference domain is held at zero while the word clock is high and counts reference cycles while it is low. That count is one half-period of the word clock in reference cycles. At each rising word-clock edge the count is decoded into two results: a rate multiple (1x, 2x, 4x or 8x of the base rate) and a base-family flag (44.1 kHz family or 48 kHz family). Both results are captured in output registers.

With a 24 MHz reference, a 44.1 kHz stream gives about 270 counts per half-period and a 48 kHz stream gives about 250. Each doubling of the rate halves the count. The outputs are sticky and change only when a measurement gives a different result. A valid flag confirms that the result has been stable over two measurements. The valid flag is withdrawn when the word clock stops.

Top module: `wck_rate_detect`

## Requirements
- R1: While rst_n is low and right after its release, fam_48 is 0, rate_mult is 00 and valid is 0.
- R2: A measurement is the number of reference cycles during which the synchronized word clock was low, taken at its next rising edge. The outputs show that measurement's result no later than 3 reference cycles after the word-clock rise.
- R3: The rate multiple is coded as rate_mult 00 = 1x for a count of 192 or more, 01 = 2x for 96 to 191, 10 = 4x for 48 to 95, and 11 = 8x below 48.
- R4: fam_48 is 1 (48 kHz family) when the count is below the family threshold for the detected multiple and 0 (44.1 kHz family) otherwise. The thresholds are 260 for 00, 130 for 01, 65 for 10 and 32 for 11.
- R5: fam_48 and rate_mult change only on a measurement and otherwise hold their value.
- R6: valid becomes 1 on a measurement whose result equals the previous measurement's result. A measurement that differs sets valid to 0.
- R7: If the synchronized word clock has no edge for 1024 reference cycles, valid goes to 0. fam_48 and rate_mult keep their value, and two new measurements are needed before valid can return.
- R8: A rising edge counts as a measurement only if a falling edge has been seen since reset or since the last stall. A partial low half is never classified.
- R9: The half-period counter saturates at 1023 and never wraps to a small value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal reference clock that all logic runs on |
| rst_n | input | 1 | Active-low synchronous reset |
| wck | input | 1 | Asynchronous audio word clock |
| fam_48 | output | 1 | Base family: 1 = 48 kHz family, 0 = 44.1 kHz family |
| rate_mult | output | 2 | Rate multiple: 00 = 1x, 01 = 2x, 10 = 4x, 11 = 8x |
| valid | output | 1 | Two consecutive measurements gave the same result |

## Verification
The embedded properties check the cycle-level rules on every cycle: the counter clears while the word clock is high and holds at saturation, the outputs hold between measurements, valid rises only on a measurement, and a stall forces valid low. The mapping from counts to codes is shown only by the bench's scenarios. These include the nominal counts for every rate, both sides of each multiple and family threshold, the ignored first rise after reset, and recovery after a stopped word clock.

// File: rtl/wck_rate_detect.sv
module wck_rate_detect #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned MUL_THR   = 48,
  parameter int unsigned FAM_THR   = 260,
  parameter int unsigned STALL_LIM = 1024
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       wck,
  output logic       fam_48,
  output logic [1:0] rate_mult,
  output logic       valid
);

  localparam int unsigned GAP_W = $clog2(STALL_LIM + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(STALL_LIM);

  logic             s1, s2, sd;
  logic             rise, fall, stall, meas, armed, have_prev;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] gap;
  logic [31:0]      cw;
  logic [1:0]       m_code;
  logic             f_code;

  always_ff @(posedge ref_clk) begin
    if (!rst_n) {s1, s2, sd} <= '0;
    else        {s1, s2, sd} <= {wck, s1, s2};
  end

  assign rise  = s2 & ~sd;
  assign fall  = ~s2 & sd;
  assign stall = (gap == GAP_LIM);
  assign meas  = rise & armed & ~stall;

  always_ff @(posedge ref_clk) begin
    if (!rst_n || s2)      cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge ref_clk) begin
    if (!rst_n || rise || fall) gap <= '0;
    else if (!stall)            gap <= gap + 1'b1;
  end

  always_ff @(posedge ref_clk) begin
    if (!rst_n || stall) armed <= 1'b0;
    else if (fall)       armed <= 1'b1;
  end

  assign cw = 32'(cnt);

  always_comb begin
    if (cw >= 4 * MUL_THR) begin
      m_code = 2'b00; f_code = (cw < FAM_THR);
    end else if (cw >= 2 * MUL_THR) begin
      m_code = 2'b01; f_code = (cw < FAM_THR / 2);
    end else if (cw >= MUL_THR) begin
      m_code = 2'b10; f_code = (cw < FAM_THR / 4);
    end else begin
      m_code = 2'b11; f_code = (cw < FAM_THR / 8);
    end
  end

  always_ff @(posedge ref_clk) begin
    if (!rst_n) begin
      fam_48 <= 1'b0; rate_mult <= 2'b00; valid <= 1'b0; have_prev <= 1'b0;
    end else if (stall) begin
      valid <= 1'b0; have_prev <= 1'b0;
    end else if (meas) begin
      valid     <= have_prev && ({f_code, m_code} == {fam_48, rate_mult});
      fam_48    <= f_code;
      rate_mult <= m_code;
      have_prev <= 1'b1;
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge ref_clk) disable iff (!rst_n)
    s2 |=> (cnt == '0)); // R2
  AST_NO_WRAP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !s2) |=> (cnt == CNT_MAX)); // R9
  AST_HOLD_CODE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !meas |=> $stable({fam_48, rate_mult})); // R5
  AST_VALID_ON_MEAS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(valid) |-> $past(meas)); // R6
  AST_STALL_DROP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stall |=> !valid); // R7
  AST_ARM_FIRST: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rise && !armed) |=> $stable({fam_48, rate_mult, valid})); // R8

endmodule

// File: tb/wck_rate_detect_test.sv
module wck_rate_detect_test;
  localparam int CLK_PER = 10;

  logic       ref_clk = 0;
  logic       rst_n = 0;
  logic       wck = 0;
  logic       fam_48, valid;
  logic [1:0] rate_mult;

  wck_rate_detect uut (.ref_clk(ref_clk), .rst_n(rst_n), .wck(wck),
                       .fam_48(fam_48), .rate_mult(rate_mult), .valid(valid));

  always #(CLK_PER/2) ref_clk = ~ref_clk;

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  logic [3:0] eq[$];
  string      tq[$];

  bit         m_armed = 0, m_have = 0, m_valid = 0;
  logic [2:0] m_code = 3'b000;

  function automatic logic [2:0] classify(int c);
    if (c >= 192)     return {c < 260, 2'b00};
    else if (c >= 96) return {c < 130, 2'b01};
    else if (c >= 48) return {c < 65,  2'b10};
    else              return {c < 32,  2'b11};
  endfunction

  task automatic check(logic [3:0] act, logic [3:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {fam,mult,valid} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic period(int lo, int hi, string tag);
    logic [2:0] c;
    @(negedge ref_clk);
    if (wck == 1'b1) m_armed = 1;
    wck = 0;
    repeat (lo) @(negedge ref_clk);
    if (m_armed) begin
      c = classify(lo);
      m_valid = m_have && (c == m_code);
      m_code = c;
      m_have = 1;
    end
    eq.push_back({m_code, m_valid});
    tq.push_back(tag);
    wck = 1;
    repeat (hi - 1) @(negedge ref_clk);
  endtask

  task automatic pair(int lo, string tag);
    period(lo, 10, tag);
    period(lo, 10, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge wck);
      repeat (4) @(negedge ref_clk);
      if (eq.size() > 0) check({fam_48, rate_mult, valid}, eq.pop_front(), tq.pop_front());
    end
  end

  initial begin : driver
    repeat (4) @(negedge ref_clk);
    check({fam_48, rate_mult, valid}, 4'b0000, "R1 in reset");
    rst_n = 1;
    @(negedge ref_clk);
    check({fam_48, rate_mult, valid}, 4'b0000, "R1 after release");
    period(30, 10, "R8 partial first low ignored");
    pair(272, "R4 44.1k 1x");
    pair(250, "R4 48k 1x");
    pair(135, "R3 88.2k 2x");
    pair(124, "R3 96k 2x");
    pair(67,  "R3 176.4k 4x");
    pair(61,  "R3 192k 4x");
    pair(34,  "R3 352.8k 8x");
    pair(31,  "R4 384k 8x");
    pair(192, "R3 edge 192");
    pair(191, "R3 edge 191");
    pair(96,  "R3 edge 96");
    pair(95,  "R3 edge 95");
    pair(48,  "R3 edge 48");
    pair(47,  "R3 edge 47");
    pair(32,  "R4 edge 32");
    pair(260, "R4 edge 260");
    pair(259, "R4 edge 259");
    pair(1020, "R9 long low no wrap");
    period(272, 10, "R6 change drops valid");
    period(250, 10, "R6 change drops valid");
    period(250, 10, "R6 repeat sets valid");
    // R7 stall: word clock stopped low
    @(negedge ref_clk);
    wck = 0;
    repeat (1200) @(negedge ref_clk);
    m_armed = 0; m_have = 0; m_valid = 0;
    check({fam_48, rate_mult, valid}, {m_code, 1'b0}, "R7 stall drops valid, holds code");
    period(20, 10, "R8 rise after stall ignored");
    period(124, 10, "R7 first after stall not valid");
    period(124, 10, "R7 second after stall valid");
    period(135, 10, "R5 hold check");
    repeat (6) @(negedge ref_clk);
    check({fam_48, rate_mult, valid}, {m_code, m_valid}, "R5 held between measurements");
    repeat (10) @(negedge ref_clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule